// File: doc/BRIEF.md
# Auto-Reloading Audio DMA Address Generator

This block drives the address side of a streaming audio DMA channel. Software programs a base address and a transfer count into holding registers. Setting the run bit copies both values into separate working counters. The block then raises a transfer request. Each time the bus side accepts a request, the block steps the address by one 16-byte burst and counts down the remaining transfers.

When the last transfer of a buffer is accepted, the working counters reload from the holding registers in the same clock edge. The block also raises a one-cycle end pulse and sets a sticky end flag. Software can therefore write the next buffer's base and count while the current buffer is still running, and the next buffer starts with no idle cycle.

The address only counts inside a 1 MB window. The upper address bits keep the value that was loaded, and a carry out of the window is lost, so the address wraps around inside the window.

Top module: `aud_dma_addr_gen`

## Requirements
- R1: Writes to the base (select 1) or count (select 2) register never change the working address or the remaining count. The new values take effect only at the next reload.
- R2: A write to the control register (select 0) with bit 0 set makes the run bit 1 and reloads the working address and count from the holding registers. From the next cycle, `xfer_addr` equals the programmed base with bits 1:0 cleared.
- R3: A transfer is accepted when `xfer_req` and `xfer_ack` are both high in the same cycle. In the following cycle, `xfer_addr` bits 19:2 have advanced by 4, which is 0x10 bytes.
- R4: A carry out of bit 19 is discarded. Bits 31:20 keep the loaded value. Bits 1:0 of `xfer_addr` are always 0.
- R5: `xfer_req` is high exactly when the run bit is 1 and the remaining count is nonzero. After reset, all outputs are 0.
- R6: When the accepted transfer is the last one of the buffer, two things happen in the next cycle. `end_pulse` is high for that one cycle. The address and count already hold the values reloaded from the holding registers, so requests continue with no gap.
- R7: With a count of 0 loaded, no request is made and neither `end_pulse` nor `end_irq` is raised.
- R8: A control write with bit 0 clear stops requests from the next cycle. A transfer accepted in the cycle of that write still completes. Afterwards the address and count hold, and `xfer_ack` has no effect.
- R9: `end_irq` is set together with `end_pulse`. A status write (select 3) with bit 0 set clears it without touching the counters. If the clear and a new end event fall in the same cycle, the flag stays set.
- R10: A start write in the same cycle as the last accepted transfer causes one reload from the holding registers, and the end event is still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 base, 2 count, 3 status |
| cfg_wdata | input | 32 | Register write data |
| xfer_req | output | 1 | Transfer request |
| xfer_ack | input | 1 | Transfer accepted when high together with `xfer_req` |
| xfer_addr | output | 32 | Address of the current 16-byte burst |
| end_pulse | output | 1 | One-cycle end-of-buffer event |
| end_irq | output | 1 | Sticky end-of-buffer flag, cleared by a status write of 1 |

## Verification
Two actions can land on the same clock edge: the end-of-buffer reload, and a software register write, either a status clear or a start. The bench provokes this by loading a one-transfer buffer with acknowledge held low, then driving the acknowledge and the write together. In the clear case, it checks that the end flag stays set. In the start case, it checks that exactly one reload from the holding registers occurs while the end event is still reported. A behavioural reference model compares the request, address, pulse and flag on every cycle, including during stretches with a pseudo-random acknowledge pattern.

// File: rtl/aud_dma_pkg.sv
package aud_dma_pkg;

  // Register select codes seen on cfg_sel
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_BASE   = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_STATUS = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/aud_dma_rst_sync.sv
module aud_dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/aud_dma_cfg_regs.sv
module aud_dma_cfg_regs
  import aud_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:2] base_q,
  output logic [CNT_W-1:0]  count_q,
  output logic              run_q,
  output logic              start_ld,
  output logic              irq_clr
);

  cfg_sel_e           sel;
  logic               wr_ctrl, wr_base, wr_count, wr_status;
  logic [ADDR_W-1:2]  base_d;
  logic [CNT_W-1:0]   count_d;
  logic               run_d;

  assign sel = cfg_sel_e'(cfg_sel);

  always_comb begin
    wr_ctrl   = cfg_we && (sel == SEL_CTRL);
    wr_base   = cfg_we && (sel == SEL_BASE);
    wr_count  = cfg_we && (sel == SEL_COUNT);
    wr_status = cfg_we && (sel == SEL_STATUS);
    base_d    = cfg_wdata[ADDR_W-1:2];
    count_d   = cfg_wdata[CNT_W-1:0];
    run_d     = cfg_wdata[0];
  end

  assign start_ld = wr_ctrl && cfg_wdata[0];
  assign irq_clr  = wr_status && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (wr_base) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (wr_count) begin
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (wr_ctrl) begin
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/aud_dma_addr_ctr.sv
module aud_dma_addr_ctr #(
  parameter int ADDR_W     = 32,
  parameter int WIN_BITS   = 20,
  parameter int STEP_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:2] load_addr,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr_q
);

  localparam int FW = WIN_BITS - 2;
  localparam logic [FW-1:0] STEP = FW'(STEP_BYTES / 4);

  logic [FW-1:0] field_q, field_d;
  logic          field_en;

  always_comb begin
    field_en = load || advance;
    field_d  = field_q;
    if (load) begin
      field_d = load_addr[WIN_BITS-1:2];
    end else if (advance) begin
      field_d = field_q + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= '0;
    end else if (field_en) begin
      field_q <= field_d;
    end
  end

  generate
    if (WIN_BITS < ADDR_W) begin : g_upper
      logic [ADDR_W-1:WIN_BITS] upper_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          upper_q <= '0;
        end else if (load) begin
          upper_q <= load_addr[ADDR_W-1:WIN_BITS];
        end
      end

      assign addr_q = {upper_q, field_q, 2'b00};
    end else begin : g_flat
      assign addr_q = {field_q, 2'b00};
    end
  endgenerate

endmodule

// File: rtl/aud_dma_xfer_ctr.sv
module aud_dma_xfer_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             dec,
  output logic [CNT_W-1:0] left_q,
  output logic             last
);

  logic [CNT_W-1:0] left_d;
  logic             left_en;

  assign last = dec && (left_q == CNT_W'(1));

  always_comb begin
    left_en = load || dec;
    left_d  = left_q;
    if (load) begin
      left_d = load_cnt;
    end else if (dec) begin
      left_d = left_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (left_en) begin
      left_q <= left_d;
    end
  end

endmodule

// File: rtl/aud_dma_end_irq.sv
module aud_dma_end_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic pulse_q,
  output logic flag_q
);

  logic flag_d, flag_en;

  always_comb begin
    flag_en = evt || clr;
    flag_d  = evt ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/aud_dma_addr_gen.sv
module aud_dma_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int WIN_BITS   = 20,
  parameter int STEP_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              xfer_req,
  input  logic              xfer_ack,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic              end_pulse,
  output logic              end_irq
);

  logic              rst_sync_n;
  logic [ADDR_W-1:2] base_q;
  logic [CNT_W-1:0]  count_q;
  logic              run_q;
  logic              start_ld;
  logic              irq_clr;
  logic [CNT_W-1:0]  left_q;
  logic              last;
  logic              fire;
  logic              reload;

  aud_dma_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  aud_dma_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .base_q    (base_q),
    .count_q   (count_q),
    .run_q     (run_q),
    .start_ld  (start_ld),
    .irq_clr   (irq_clr)
  );

  assign xfer_req = run_q && (left_q != '0);
  assign fire     = xfer_req && xfer_ack;
  assign reload   = start_ld || last;

  aud_dma_xfer_ctr #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (reload),
    .load_cnt (count_q),
    .dec      (fire),
    .left_q   (left_q),
    .last     (last)
  );

  aud_dma_addr_ctr #(
    .ADDR_W     (ADDR_W),
    .WIN_BITS   (WIN_BITS),
    .STEP_BYTES (STEP_BYTES)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (reload),
    .load_addr (base_q),
    .advance   (fire),
    .addr_q    (xfer_addr)
  );

  aud_dma_end_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .evt     (last),
    .clr     (irq_clr),
    .pulse_q (end_pulse),
    .flag_q  (end_irq)
  );

endmodule

// File: rtl/aud_dma_addr_gen_chk.sv
module aud_dma_addr_gen_chk #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int WIN_BITS   = 20,
  parameter int STEP_BYTES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_req,
  input logic              xfer_ack,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic              end_pulse,
  input logic              end_irq,
  input logic              run_q,
  input logic [CNT_W-1:0]  left_q,
  input logic              start_ld,
  input logic              irq_clr,
  input logic              last
);

  localparam int FW = WIN_BITS - 2;

  // R4
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_addr[1:0] == 2'b00);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_ack && !last && !start_ld) |=>
      xfer_addr[WIN_BITS-1:2] == $past(xfer_addr[WIN_BITS-1:2]) + FW'(STEP_BYTES / 4));

  // R4
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_ack && !last && !start_ld) |=>
      $stable(xfer_addr[ADDR_W-1:WIN_BITS]));

  // R5
  req_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !xfer_req);

  // R6
  end_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_ack && left_q == CNT_W'(1)) |=> end_pulse);

  // R6
  end_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |-> $past(xfer_req && xfer_ack));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_req && !start_ld) |=> $stable(xfer_addr));

  // R9
  flag_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |-> end_irq);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !last) |=> !end_irq);

endmodule

bind aud_dma_addr_gen aud_dma_addr_gen_chk #(
  .ADDR_W     (ADDR_W),
  .CNT_W      (CNT_W),
  .WIN_BITS   (WIN_BITS),
  .STEP_BYTES (STEP_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .xfer_req  (xfer_req),
  .xfer_ack  (xfer_ack),
  .xfer_addr (xfer_addr),
  .end_pulse (end_pulse),
  .end_irq   (end_irq),
  .run_q     (run_q),
  .left_q    (left_q),
  .start_ld  (start_ld),
  .irq_clr   (irq_clr),
  .last      (last)
);

// File: tb/tb_aud_dma_addr_gen.sv
`timescale 1ns/1ps
module tb_aud_dma_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        xfer_ack = 1'b0;
  logic        xfer_req;
  logic [31:0] xfer_addr;
  logic        end_pulse;
  logic        end_irq;

  always #2.5 clk = ~clk;

  aud_dma_addr_gen dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .xfer_req  (xfer_req),
    .xfer_ack  (xfer_ack),
    .xfer_addr (xfer_addr),
    .end_pulse (end_pulse),
    .end_irq   (end_irq)
  );

  int          checks = 0;
  int          errors = 0;
  int          ack_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit          done = 1'b0;
  logic [31:0] saved_addr;

  // Behavioural reference model
  bit          m_run;
  logic [31:0] m_base, m_addr, n_addr;
  int          m_cnt, m_left, n_left;
  bit          m_pulse, m_irq;
  bit          m_fire, m_last, m_start, m_clr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_base = 0; m_addr = 0; m_cnt = 0; m_left = 0;
      m_pulse = 0; m_irq = 0;
    end else begin
      m_fire  = m_run && (m_left != 0) && xfer_ack;
      m_last  = m_fire && (m_left == 1);
      m_start = cfg_we && (cfg_sel == 2'd0) && cfg_wdata[0];
      m_clr   = cfg_we && (cfg_sel == 2'd3) && cfg_wdata[0];
      n_addr  = m_addr;
      n_left  = m_left;
      if (m_start || m_last) begin
        n_addr = m_base;
        n_left = m_cnt;
      end else if (m_fire) begin
        n_addr = (m_addr & 32'hFFF0_0000) | ((m_addr + 32'd16) & 32'h000F_FFFC);
        n_left = m_left - 1;
      end
      m_addr  = n_addr;
      m_left  = n_left;
      m_pulse = m_last;
      if (m_last) m_irq = 1;
      else if (m_clr) m_irq = 0;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: m_run = cfg_wdata[0];
          2'd1: m_base = cfg_wdata & 32'hFFFF_FFFC;
          2'd2: m_cnt = int'(cfg_wdata[15:0]);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(xfer_req === (m_run && m_left != 0), "R5 xfer_req vs model", {31'd0, xfer_req}, {31'd0, m_run && m_left != 0});
      chk(xfer_addr === m_addr, "R3 xfer_addr vs model", xfer_addr, m_addr);
      chk(end_pulse === m_pulse, "R6 end_pulse vs model", {31'd0, end_pulse}, {31'd0, m_pulse});
      chk(end_irq === m_irq, "R9 end_irq vs model", {31'd0, end_irq}, {31'd0, m_irq});
    end
  end

  task automatic step(input bit we, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we    = we;
    cfg_sel   = sel;
    cfg_wdata = d;
    case (ack_mode)
      0: xfer_ack = 1'b0;
      1: xfer_ack = 1'b1;
      default: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        xfer_ack = lfsr[0];
      end
    endcase
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 32'd0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    chk(xfer_req == 1'b0 && end_pulse == 1'b0, "R5 reset outputs", {31'd0, xfer_req}, 32'd0);
    chk(xfer_addr == 32'd0 && end_irq == 1'b0, "R5 reset addr/flag", xfer_addr, 32'd0);

    // Wrap inside the window, then gapless reload
    ack_mode = 0;
    step(1'b1, 2'd1, 32'h456F_FFE3);
    step(1'b1, 2'd2, 32'd4);
    step(1'b1, 2'd0, 32'd1);
    ack_mode = 1;
    idle(1);
    chk(xfer_addr == 32'h456F_FFE0, "R2 start loads base", xfer_addr, 32'h456F_FFE0);
    idle(1);
    chk(xfer_addr == 32'h456F_FFF0, "R3 first step", xfer_addr, 32'h456F_FFF0);
    idle(1);
    chk(xfer_addr == 32'h4560_0000, "R4 wrap keeps upper bits", xfer_addr, 32'h4560_0000);
    idle(1);
    chk(xfer_addr == 32'h4560_0010, "R3 step after wrap", xfer_addr, 32'h4560_0010);
    idle(1);
    chk(end_pulse == 1'b1, "R6 end pulse", {31'd0, end_pulse}, 32'd1);
    chk(xfer_addr == 32'h456F_FFE0 && xfer_req == 1'b1, "R6 gapless reload", xfer_addr, 32'h456F_FFE0);

    // Queue next buffer while running
    ack_mode = 0;
    step(1'b1, 2'd1, 32'h0AB0_0100);
    step(1'b1, 2'd2, 32'd2);
    idle(1);
    chk(xfer_addr == 32'h456F_FFF0, "R1 holding write leaves counter", xfer_addr, 32'h456F_FFF0);
    ack_mode = 1;
    idle(4);
    chk(xfer_addr == 32'h0AB0_0100 && end_pulse == 1'b1, "R1 queued buffer picked up", xfer_addr, 32'h0AB0_0100);

    ack_mode = 2;
    idle(200);

    // Clear flag alone
    ack_mode = 0;
    step(1'b1, 2'd0, 32'd0);
    idle(1);
    saved_addr = xfer_addr;
    step(1'b1, 2'd3, 32'd1);
    idle(1);
    chk(end_irq == 1'b0, "R9 clear flag", {31'd0, end_irq}, 32'd0);
    chk(xfer_addr == saved_addr, "R9 clear leaves address", xfer_addr, saved_addr);

    // Stop mid-buffer
    step(1'b1, 2'd1, 32'h7FF0_0040);
    step(1'b1, 2'd2, 32'd5);
    step(1'b1, 2'd0, 32'd1);
    ack_mode = 1;
    idle(2);
    step(1'b1, 2'd0, 32'd0);
    idle(1);
    chk(xfer_req == 1'b0, "R8 stop drops request", {31'd0, xfer_req}, 32'd0);
    chk(xfer_addr == 32'h7FF0_0070, "R8 in-flight transfer completes", xfer_addr, 32'h7FF0_0070);
    idle(3);
    chk(xfer_addr == 32'h7FF0_0070 && end_pulse == 1'b0, "R8 ack ignored when stopped", xfer_addr, 32'h7FF0_0070);
    step(1'b1, 2'd0, 32'd1);
    idle(1);
    chk(xfer_addr == 32'h7FF0_0040, "R2 restart reloads base", xfer_addr, 32'h7FF0_0040);

    // Zero count
    ack_mode = 0;
    step(1'b1, 2'd0, 32'd0);
    step(1'b1, 2'd3, 32'd1);
    step(1'b1, 2'd2, 32'd0);
    step(1'b1, 2'd0, 32'd1);
    ack_mode = 1;
    idle(5);
    chk(xfer_req == 1'b0, "R7 zero count no request", {31'd0, xfer_req}, 32'd0);
    chk(end_irq == 1'b0 && end_pulse == 1'b0, "R7 zero count no interrupt", {31'd0, end_irq}, 32'd0);

    // Clear colliding with end event
    ack_mode = 0;
    step(1'b1, 2'd2, 32'd1);
    step(1'b1, 2'd0, 32'd1);
    idle(1);
    ack_mode = 1;
    step(1'b1, 2'd3, 32'd1);
    idle(1);
    chk(end_irq == 1'b1, "R9 set wins over clear", {31'd0, end_irq}, 32'd1);
    chk(end_pulse == 1'b1, "R9 pulse with collision", {31'd0, end_pulse}, 32'd1);

    // Start colliding with last transfer
    ack_mode = 0;
    step(1'b1, 2'd1, 32'h2220_0000);
    ack_mode = 1;
    step(1'b1, 2'd0, 32'd1);
    ack_mode = 0;
    idle(1);
    chk(end_pulse == 1'b1, "R10 end reported with start", {31'd0, end_pulse}, 32'd1);
    chk(xfer_addr == 32'h2220_0000 && xfer_req == 1'b1, "R10 single reload", xfer_addr, 32'h2220_0000);

    step(1'b1, 2'd2, 32'd7);
    ack_mode = 2;
    idle(300);
    finish_run();
  end

endmodule